// File: doc/BRIEF.md
# DDR Burst Word Select and Mask Unit

This unit connects 16-bit word-addressed clients to a DDR3 PHY that always moves bursts of eight beats. It splits a client's linear 16-bit address into a row and a column. The three low column bits are rewritten so that the wanted word reaches the beat the read path samples. For a write, it copies the client word into every beat of the outgoing burst. It also builds an active-low per-beat mask, so that only one beat is stored.

For a read, the PHY delivers a deserialized 128-bit burst. The unit takes one fixed beat out of it and rebuilds the 16-bit word from the two byte halves. It takes this word at one fixed phase of a free-running ten-phase counter on the fast clock. It then holds the word for a whole counter period, so a client running at one tenth of the rate always sees a settled value. Two clients share the unit. A channel select picks which client supplies the address, the data, the write flag and the mask offset.

Top module: `burst_word_lane`

## Requirements
- R1: On a cycle with `row_cmd` high, `row_addr` takes bits 15:10 of the selected client's address, zero-extended. It holds its value on every other cycle.
- R2: On a cycle with `col_cmd` high, `col_addr` takes {zeros, address bits 9:3, remapped offset}, where the remapped offset is 7 for address bits 2:0 equal to 0 and k-1 for any other value k. It holds its value otherwise.
- R3: On a column command, `wr_burst` takes the selected client's data word in all eight beats. Beat b occupies bits b*16+15 down to b*16.
- R4: On a column command, `beat_mask` is all ones except for a single zero at bit position equal to address bits 2:0. Bit b masks beat b.
- R5: With `chan_sel` at 0, the primary client's address, data and write flag are used, including the mask offset. With `chan_sel` at 1, the secondary client's are used.
- R6: `dq_oe` takes the selected client's write flag at each column command and holds it until the next one.
- R7: `phase` counts 0,1,...,9 and wraps to 0, advancing once per clock.
- R8: On the clock edge where `phase` is 7, `rd_word` loads {rd_burst[103:96], rd_burst[39:32]}. The value is visible from the next cycle.
- R9: `rd_word` does not change on any edge where `phase` is not 7.
- R10: While `rst` is high, the outputs return to `row_addr`=0, `col_addr`=0, `wr_burst`=0, `beat_mask`=8'hFF, `dq_oe`=0, `rd_word`=0 and `phase`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_sel | input | 1 | 0 selects the primary client, 1 the secondary |
| pri_addr | input | 16 | Primary client linear word address |
| pri_wdata | input | 16 | Primary client write word |
| pri_write | input | 1 | Primary client write flag (1 = write) |
| sec_addr | input | 16 | Secondary client linear word address |
| sec_wdata | input | 16 | Secondary client write word |
| sec_write | input | 1 | Secondary client write flag (1 = write) |
| row_cmd | input | 1 | Latch the row address this cycle |
| col_cmd | input | 1 | Latch the column, burst data, mask and tristate enable this cycle |
| rd_burst | input | 128 | Deserialized read burst: low bytes in 63:0, high bytes in 127:64 |
| row_addr | output | 15 | Row address to the PHY |
| col_addr | output | 15 | Column address to the PHY |
| wr_burst | output | 128 | Eight-beat write data |
| beat_mask | output | 8 | Per-beat data mask, high = masked |
| dq_oe | output | 1 | Data-line drive enable |
| rd_word | output | 16 | Captured read word for the slow client |
| phase | output | 4 | Fast-clock phase counter |

## Verification
The hardest case to reach from the ports is a read whose word depends on the remap, the mask and the capture phase all at once. A wrong remap or a leaking mask shows up only after neighbouring words in the same burst have been written and one of them is read back at the sampled beat. The stimulus writes 32 consecutive addresses, so that four bursts are each filled word by word. It then reads every address back through a behavioural burst memory, which stores only unmasked beats and rotates the returned beats by the column's low bits. Each read waits for the capture phase. During every access the unselected client carries conflicting values, so any leak through the channel select shows up.

// File: rtl/burst_lane_pkg.sv
package burst_lane_pkg;

    localparam int ADDR_W  = 16;
    localparam int WORD_W  = 16;
    localparam int BEATS   = 8;
    localparam int OFS_W   = $clog2(BEATS);
    localparam int ROW_LSB = 10;
    localparam int BYTE_W  = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic              wr;
    } client_req_t;

    // Beat offset rewrite: 0 goes to the top beat, every other k to k-1.
    function automatic logic [OFS_W-1:0] beat_remap(input logic [OFS_W-1:0] k);
        return k - OFS_W'(1);
    endfunction

    // Active-low single-beat enable: all beats masked except beat k.
    function automatic logic [BEATS-1:0] beat_keep(input logic [OFS_W-1:0] k);
        logic [BEATS-1:0] m;
        m    = '1;
        m[k] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/bwl_phase_ctr.sv
module bwl_phase_ctr
#(
    parameter int PHASES    = 10,
    parameter int CAP_PHASE = 7,
    localparam int PH_W     = $clog2(PHASES)
)(
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            cap_now
);

    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    always_ff @(posedge clk) begin
        if (rst)               phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + PH_W'(1);
    end

    assign cap_now = (phase == PH_W'(CAP_PHASE));

    assert_phase_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST) |=> (phase == '0));
    assert_phase_step_R7: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> (phase == $past(phase) + PH_W'(1)));

endmodule

// File: rtl/bwl_client_mux.sv
module bwl_client_mux
    import burst_lane_pkg::*;
(
    input  logic        chan_sel,
    input  client_req_t pri_req,
    input  client_req_t sec_req,
    output client_req_t sel_req
);

    always_comb begin
        sel_req = chan_sel ? sec_req : pri_req;
    end

endmodule

// File: rtl/bwl_cmd_path.sv
module bwl_cmd_path
    import burst_lane_pkg::*;
#(
    parameter int ROW_W = 15,
    parameter int COL_W = 15
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    row_cmd,
    input  logic                    col_cmd,
    input  client_req_t             req,
    output logic [ROW_W-1:0]        row_addr,
    output logic [COL_W-1:0]        col_addr,
    output logic [BEATS*WORD_W-1:0] wr_burst,
    output logic [BEATS-1:0]        beat_mask,
    output logic                    dq_oe
);

    localparam int ROW_BITS = ADDR_W - ROW_LSB;
    localparam int COL_BITS = ROW_LSB;

    logic [ROW_BITS-1:0]     row_part;
    logic [COL_BITS-1:0]     col_part;
    logic [OFS_W-1:0]        ofs;
    logic [BEATS*WORD_W-1:0] burst_next;

    assign ofs      = req.addr[OFS_W-1:0];
    assign row_part = req.addr[ADDR_W-1:ROW_LSB];
    assign col_part = {req.addr[ROW_LSB-1:OFS_W], beat_remap(ofs)};

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        assign burst_next[b*WORD_W +: WORD_W] = req.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_addr <= '0;
        end else if (row_cmd) begin
            row_addr <= ROW_W'(row_part);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_addr  <= '0;
            wr_burst  <= '0;
            beat_mask <= '1;
            dq_oe     <= 1'b0;
        end else if (col_cmd) begin
            col_addr  <= COL_W'(col_part);
            wr_burst  <= burst_next;
            beat_mask <= beat_keep(ofs);
            dq_oe     <= req.wr;
        end
    end

    assert_row_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !row_cmd |=> $stable(row_addr));
    assert_col_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !col_cmd |=> $stable(col_addr));
    assert_mask_single_R4: assert property (@(posedge clk) disable iff (rst)
        col_cmd |=> ($countones(beat_mask) == BEATS - 1));
    assert_oe_follows_write_R6: assert property (@(posedge clk) disable iff (rst)
        !col_cmd |=> $stable(dq_oe));

endmodule

// File: rtl/bwl_read_capture.sv
module bwl_read_capture
    import burst_lane_pkg::*;
#(
    parameter int CAP_BEAT = 4
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cap_now,
    input  logic [BEATS*WORD_W-1:0] rd_burst,
    output logic [WORD_W-1:0]       rd_word
);

    localparam int LANES  = WORD_W / BYTE_W;
    localparam int PLANE  = BEATS * BYTE_W;

    logic [WORD_W-1:0] picked;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign picked[j*BYTE_W +: BYTE_W] = rd_burst[j*PLANE + CAP_BEAT*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_word <= '0;
        else if (cap_now) rd_word <= picked;
    end

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !cap_now |=> $stable(rd_word));
    assert_rd_take_R8: assert property (@(posedge clk) disable iff (rst)
        cap_now |=> (rd_word == {$past(rd_burst[BEATS*WORD_W-PLANE+CAP_BEAT*BYTE_W +: BYTE_W]),
                                 $past(rd_burst[CAP_BEAT*BYTE_W +: BYTE_W])}));

endmodule

// File: rtl/burst_word_lane.sv
module burst_word_lane
    import burst_lane_pkg::*;
#(
    parameter int ROW_W     = 15,
    parameter int COL_W     = 15,
    parameter int PHASES    = 10,
    parameter int CAP_PHASE = 7,
    parameter int CAP_BEAT  = 4,
    localparam int PH_W     = $clog2(PHASES),
    localparam int BUS_W    = BEATS * WORD_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_sel,
    input  logic [ADDR_W-1:0] pri_addr,
    input  logic [WORD_W-1:0] pri_wdata,
    input  logic              pri_write,
    input  logic [ADDR_W-1:0] sec_addr,
    input  logic [WORD_W-1:0] sec_wdata,
    input  logic              sec_write,
    input  logic              row_cmd,
    input  logic              col_cmd,
    input  logic [BUS_W-1:0]  rd_burst,
    output logic [ROW_W-1:0]  row_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic [BUS_W-1:0]  wr_burst,
    output logic [BEATS-1:0]  beat_mask,
    output logic              dq_oe,
    output logic [WORD_W-1:0] rd_word,
    output logic [PH_W-1:0]   phase
);

    client_req_t pri_req, sec_req, sel_req;
    logic        cap_now;

    assign pri_req = '{addr: pri_addr, wdata: pri_wdata, wr: pri_write};
    assign sec_req = '{addr: sec_addr, wdata: sec_wdata, wr: sec_write};

    bwl_phase_ctr #(.PHASES(PHASES), .CAP_PHASE(CAP_PHASE)) u_phase (
        .clk(clk), .rst(rst), .phase(phase), .cap_now(cap_now)
    );

    bwl_client_mux u_mux (
        .chan_sel(chan_sel), .pri_req(pri_req), .sec_req(sec_req), .sel_req(sel_req)
    );

    bwl_cmd_path #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cmd (
        .clk(clk), .rst(rst), .row_cmd(row_cmd), .col_cmd(col_cmd), .req(sel_req),
        .row_addr(row_addr), .col_addr(col_addr), .wr_burst(wr_burst),
        .beat_mask(beat_mask), .dq_oe(dq_oe)
    );

    bwl_read_capture #(.CAP_BEAT(CAP_BEAT)) u_rd (
        .clk(clk), .rst(rst), .cap_now(cap_now), .rd_burst(rd_burst), .rd_word(rd_word)
    );

    // R5: the mask zero must sit at the offset of the selected client.
    assert_mask_from_selected_R5: assert property (@(posedge clk) disable iff (rst)
        col_cmd |=> (beat_mask[$past(chan_sel ? sec_addr[OFS_W-1:0] : pri_addr[OFS_W-1:0])] == 1'b0));

endmodule

// File: tb/test_burst_word_lane.sv
module test_burst_word_lane;

    logic         clk = 0;
    logic         rst;
    logic         chan_sel;
    logic [15:0]  pri_addr, pri_wdata, sec_addr, sec_wdata;
    logic         pri_write, sec_write, row_cmd, col_cmd;
    logic [127:0] rd_burst;
    logic [14:0]  row_addr, col_addr;
    logic [127:0] wr_burst;
    logic [7:0]   beat_mask;
    logic         dq_oe;
    logic [15:0]  rd_word;
    logic [3:0]   phase;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done   = 0;

    logic [15:0] dram [int];

    always #10 clk = ~clk;

    burst_word_lane i_burst_word_lane (
        .clk(clk), .rst(rst), .chan_sel(chan_sel),
        .pri_addr(pri_addr), .pri_wdata(pri_wdata), .pri_write(pri_write),
        .sec_addr(sec_addr), .sec_wdata(sec_wdata), .sec_write(sec_write),
        .row_cmd(row_cmd), .col_cmd(col_cmd), .rd_burst(rd_burst),
        .row_addr(row_addr), .col_addr(col_addr), .wr_burst(wr_burst),
        .beat_mask(beat_mask), .dq_oe(dq_oe), .rd_word(rd_word), .phase(phase)
    );

    // Reference model, updated at each edge from the stable inputs
    logic [3:0]   e_phase;
    logic [14:0]  e_row, e_col;
    logic [127:0] e_wb;
    logic [7:0]   e_dm;
    logic         e_oe;
    logic [15:0]  e_rd;

    wire [15:0] s_addr = chan_sel ? sec_addr  : pri_addr;
    wire [15:0] s_data = chan_sel ? sec_wdata : pri_wdata;
    wire        s_wr   = chan_sel ? sec_write : pri_write;

    always @(posedge clk) begin
        if (rst) begin
            e_phase <= 0; e_row <= 0; e_col <= 0; e_wb <= 0;
            e_dm <= 8'hFF; e_oe <= 0; e_rd <= 0;
        end else begin
            e_phase <= (e_phase == 9) ? 4'd0 : e_phase + 4'd1;
            if (e_phase == 7) e_rd <= {rd_burst[103:96], rd_burst[39:32]};
            if (row_cmd) e_row <= {9'd0, s_addr[15:10]};
            if (col_cmd) begin
                e_col <= {5'd0, s_addr[9:3], (s_addr[2:0] == 0) ? 3'd7 : s_addr[2:0] - 3'd1};
                e_wb  <= {8{s_data}};
                e_dm  <= ~(8'd1 << s_addr[2:0]);
                e_oe  <= s_wr;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(phase == e_phase,     "R7 phase",     phase, e_phase);
            check(row_addr == e_row,    "R1 row_addr",  row_addr, e_row);
            check(col_addr == e_col,    "R2 col_addr",  col_addr, e_col);
            check(wr_burst == e_wb,     "R3 wr_burst",  wr_burst, e_wb);
            check(beat_mask == e_dm,    "R4 beat_mask", beat_mask, e_dm);
            check(dq_oe == e_oe,        "R6 dq_oe",     dq_oe, e_oe);
            check(rd_word == e_rd,      "R8/R9 rd_word", rd_word, e_rd);
        end
    end

    function automatic int mkey(input logic [14:0] r, input logic [14:0] c, input int beat);
        return (int'(r[5:0]) << 10) | (int'(c[9:3]) << 3) | beat;
    endfunction

    // One access: row command, column command, then memory model action
    task automatic access(input bit ch, input logic [15:0] a, input logic [15:0] d, input bit wr);
        @(negedge clk);
        chan_sel = ch;
        if (ch) begin
            sec_addr = a; sec_wdata = d; sec_write = wr;
            pri_addr = ~a; pri_wdata = ~d; pri_write = ~wr;
        end else begin
            pri_addr = a; pri_wdata = d; pri_write = wr;
            sec_addr = ~a; sec_wdata = ~d; sec_write = ~wr;
        end
        row_cmd = 1;
        @(negedge clk);
        row_cmd = 0; col_cmd = 1;
        @(negedge clk);
        col_cmd = 0;
        if (wr) begin
            for (int b = 0; b < 8; b++)
                if (!beat_mask[b]) dram[mkey(row_addr, col_addr, b)] = wr_burst[b*16 +: 16];
        end else begin
            for (int p = 0; p < 8; p++) begin
                int k;
                logic [15:0] w;
                k = mkey(row_addr, col_addr, (p + int'(col_addr[2:0]) + 5) % 8);
                w = dram.exists(k) ? dram[k] : 16'h0;
                rd_burst[p*8 +: 8]      = w[7:0];
                rd_burst[64 + p*8 +: 8] = w[15:8];
            end
            while (phase != 4'd8) @(negedge clk);
            check(rd_word == d, ch ? "R8 readback secondary" : "R5 readback primary", rd_word, d);
        end
    endtask

    initial begin
        rst = 1; chan_sel = 0; row_cmd = 0; col_cmd = 0; rd_burst = '0;
        pri_addr = 0; pri_wdata = 0; pri_write = 0;
        sec_addr = 0; sec_wdata = 0; sec_write = 0;
        repeat (3) @(negedge clk);
        check(row_addr == 0 && col_addr == 0 && wr_burst == 0, "R10 reset addr/data",
              {row_addr, col_addr}, 0);
        check(beat_mask == 8'hFF && dq_oe == 0, "R10 reset mask/oe", {beat_mask, dq_oe}, 9'h1FE);
        check(rd_word == 0 && phase == 0, "R10 reset rd/phase", {rd_word, phase}, 0);
        cmp_on = 1;
        rst = 0;
        for (int i = 0; i < 32; i++)
            access(1, 16'(i), 16'(i * 16'h0931) ^ 16'hC35A, 1);
        for (int i = 0; i < 32; i++)
            access(1, 16'(i), 16'(i * 16'h0931) ^ 16'hC35A, 0);
        for (int i = 0; i < 8; i++)
            access(0, 16'h0400 + 16'(i), 16'h7E00 + 16'(i * 37), 1);
        for (int i = 7; i >= 0; i--)
            access(0, 16'h0400 + 16'(i), 16'h7E00 + 16'(i * 37), 0);
        access(1, 16'hFFFF, 16'hBEEF, 1);
        access(1, 16'hFFF8, 16'h1234, 1);
        access(0, 16'hFFFF, 16'hBEEF, 0);
        access(1, 16'hFFF8, 16'h1234, 0);
        repeat (12) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule